// File: doc/BRIEF.md
# Late-Write Synchronous SRAM

This block is a synthesizable model of a synchronous static RAM that never needs an idle cycle when the bus turns from reading to writing. The array is built from 9-bit bytes, two per word by default, and its depth is a parameter. The rising clock edge samples the address, the read/write control, the byte enables and the chip selects. Write data follows its address later: one cycle later in flow-through mode and two cycles later in pipelined mode. A static mode input chooses between the two modes. In flow-through mode the read data is combinational from the sampled address. In pipelined mode an output register adds one cycle of read latency.

Because write data lags its address, a read can issue on every cycle, whatever the cycle before it was. In pipelined mode, a read can hit the address of a write whose data has not yet arrived. In that case the block merges the write data arriving on that same edge into the output register, one byte at a time. Three active-high chip selects support depth expansion. Output enable and sleep act asynchronously on the output drive. A write already in the late-write pipeline still completes if the cycles that follow are deselected.

Top module: `lw_sram`

## Requirements
- R1: An operation is accepted at a rising clock edge only when sel_a, sel_b and sel_c are all 1 and sleep is 0. Otherwise the edge issues nothing, although a write already in flight still completes.
- R2: In pipelined mode (pipe_mode=1), a read sampled at edge k drives its word on q, with q_drive=1, after edge k+1 and until edge k+2.
- R3: In flow-through mode (pipe_mode=0), a read sampled at edge k drives its word on q, with q_drive=1, after edge k and until edge k+1.
- R4: A write sampled at edge k takes its data from din at edge k+2 in pipelined mode, or at edge k+1 in flow-through mode.
- R5: Byte enable bit i (be[i]=1) writes bits 9i+8..9i. A byte whose enable is 0 keeps its previous contents.
- R6: Reads and writes may alternate on consecutive edges with no idle cycle, and each read returns the data of every earlier completed write.
- R7: In pipelined mode, a read of the address of a write that is still waiting for its data returns the bytes that write enables, taken from din, and the other bytes from memory.
- R8: A write whose data edge falls in a deselected cycle is still stored.
- R9: While oe=0, q_drive is 0 regardless of clock. Raising oe re-enables the drive without waiting for an edge.
- R10: While sleep=1, q_drive is 0 at once, new operations are ignored, and stored data is kept.
- R11: While rst_n=0, q_drive is 0 and the pipeline holds no operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low asynchronous reset of the control pipeline |
| pipe_mode | input | 1 | 1 = pipelined reads with double late write, 0 = flow-through with single late write; change only under reset |
| sel_a | input | 1 | Chip select, active high |
| sel_b | input | 1 | Chip select, active high |
| sel_c | input | 1 | Chip select, active high |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | AW (4) | Word address |
| be | input | NB (2) | Byte write enables |
| din | input | NB*9 (18) | Write data, sampled one or two edges after its address |
| oe | input | 1 | Asynchronous output enable, active high |
| sleep | input | 1 | Asynchronous power-down request, active high |
| q | output | NB*9 (18) | Read data |
| q_drive | output | 1 | 1 when q is driven; 0 stands for high impedance |

## Verification
In pipelined mode a table of cycles is played that alternates write, write, read, read, then a partial write followed at once by a read of the same address. The alternation separates the two-edge data lag and the one-cycle output latency from a design that gets either one wrong. The same-address read shows whether forwarding merges bytes or returns stale memory. Deselected cycles and partial chip selects show that a pending write still retires while a new one is refused. Directed flow-through tests then cover a write followed at once by a read, a partial-byte overwrite, mid-cycle toggles of output enable and sleep, and a reset during a live read.

// File: rtl/lw_sram_pkg.sv
package lw_sram_pkg;
    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;
endpackage

// File: rtl/lw_sram_stages.sv
// Two-stage record of accepted operations; stage 2 exists for the
// double late-write case.
module lw_sram_stages
    import lw_sram_pkg::*;
#(
    parameter int AW = 4,
    parameter int NB = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          issue,
    input  logic          is_wr,
    input  logic [AW-1:0] addr,
    input  logic [NB-1:0] be,
    output op_e           s1_op,
    output logic [AW-1:0] s1_addr,
    output logic [NB-1:0] s1_be,
    output op_e           s2_op,
    output logic [AW-1:0] s2_addr,
    output logic [NB-1:0] s2_be
);
    typedef struct packed {
        op_e           op;
        logic [AW-1:0] addr;
        logic [NB-1:0] be;
    } stage_t;

    typedef struct packed {
        stage_t s1;
        stage_t s2;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s2 = st_q.s1;
        if (issue) begin
            st_d.s1.op   = is_wr ? OP_WRITE : OP_READ;
            st_d.s1.addr = addr;
            st_d.s1.be   = be;
        end else begin
            st_d.s1.op   = OP_IDLE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{s1: '{op: OP_IDLE, addr: '0, be: '0},
                      s2: '{op: OP_IDLE, addr: '0, be: '0}};
        end else begin
            st_q <= st_d;
        end
    end

    assign s1_op   = st_q.s1.op;
    assign s1_addr = st_q.s1.addr;
    assign s1_be   = st_q.s1.be;
    assign s2_op   = st_q.s2.op;
    assign s2_addr = st_q.s2.addr;
    assign s2_be   = st_q.s2.be;
endmodule

// File: rtl/lw_sram_array.sv
// Storage: one synchronous byte-masked write port, one combinational read port.
module lw_sram_array #(
    parameter int AW = 4,
    parameter int NB = 2,
    parameter int BW = 9,
    localparam int DW    = NB * BW,
    localparam int DEPTH = 1 << AW
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] waddr,
    input  logic [NB-1:0] wbe,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [DEPTH];

    for (genvar b = 0; b < NB; b++) begin : g_lane
        always_ff @(posedge clk) begin
            if (wr_en && wbe[b]) begin
                mem[waddr][b*BW +: BW] <= wdata[b*BW +: BW];
            end
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/lw_sram_rdout.sv
// Output register for pipelined reads, with byte-wise forwarding from
// the write whose data lands on the same edge.
module lw_sram_rdout #(
    parameter int NB = 2,
    parameter int BW = 9,
    localparam int DW = NB * BW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_live,
    input  logic [DW-1:0] mem_word,
    input  logic          fwd_hit,
    input  logic [NB-1:0] fwd_be,
    input  logic [DW-1:0] fwd_data,
    output logic          out_vld,
    output logic [DW-1:0] out_word
);
    typedef struct packed {
        logic          vld;
        logic [DW-1:0] word;
    } state_t;

    state_t        st_d, st_q;
    logic [DW-1:0] merged;

    for (genvar b = 0; b < NB; b++) begin : g_merge
        assign merged[b*BW +: BW] = (fwd_hit && fwd_be[b]) ? fwd_data[b*BW +: BW]
                                                            : mem_word[b*BW +: BW];
    end

    always_comb begin
        st_d     = st_q;
        st_d.vld = rd_live;
        if (rd_live) begin
            st_d.word = merged;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{vld: 1'b0, word: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign out_vld  = st_q.vld;
    assign out_word = st_q.word;
endmodule

// File: rtl/lw_sram.sv
module lw_sram
    import lw_sram_pkg::*;
#(
    parameter int AW = 4,
    parameter int NB = 2,
    parameter int BW = 9,
    localparam int DW = NB * BW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pipe_mode,
    input  logic          sel_a,
    input  logic          sel_b,
    input  logic          sel_c,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [NB-1:0] be,
    input  logic [DW-1:0] din,
    input  logic          oe,
    input  logic          sleep,
    output logic [DW-1:0] q,
    output logic          q_drive
);
    op_e           s1_op, s2_op;
    logic [AW-1:0] s1_addr, s2_addr;
    logic [NB-1:0] s1_be, s2_be;
    logic          issue;
    logic          wr_en;
    logic [AW-1:0] waddr;
    logic [NB-1:0] wbe;
    logic [DW-1:0] rdata;
    logic          fwd_hit;
    logic          s1_rd;
    logic          preg_vld;
    logic [DW-1:0] preg_word;
    logic          data_vld;

    assign issue = sel_a && sel_b && sel_c && !sleep;

    lw_sram_stages #(.AW(AW), .NB(NB)) u_stages (
        .clk     (clk),
        .rst_n   (rst_n),
        .issue   (issue),
        .is_wr   (we),
        .addr    (addr),
        .be      (be),
        .s1_op   (s1_op),
        .s1_addr (s1_addr),
        .s1_be   (s1_be),
        .s2_op   (s2_op),
        .s2_addr (s2_addr),
        .s2_be   (s2_be)
    );

    // The write whose data is on din this cycle sits in stage 2 when
    // pipelined and in stage 1 when flow-through.
    always_comb begin
        if (pipe_mode) begin
            wr_en = (s2_op == OP_WRITE);
            waddr = s2_addr;
            wbe   = s2_be;
        end else begin
            wr_en = (s1_op == OP_WRITE);
            waddr = s1_addr;
            wbe   = s1_be;
        end
    end

    lw_sram_array #(.AW(AW), .NB(NB), .BW(BW)) u_array (
        .clk   (clk),
        .wr_en (wr_en),
        .waddr (waddr),
        .wbe   (wbe),
        .wdata (din),
        .raddr (s1_addr),
        .rdata (rdata)
    );

    assign s1_rd   = (s1_op == OP_READ);
    assign fwd_hit = pipe_mode && s1_rd && (s2_op == OP_WRITE) && (s2_addr == s1_addr);

    lw_sram_rdout #(.NB(NB), .BW(BW)) u_rdout (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_live  (pipe_mode && s1_rd),
        .mem_word (rdata),
        .fwd_hit  (fwd_hit),
        .fwd_be   (s2_be),
        .fwd_data (din),
        .out_vld  (preg_vld),
        .out_word (preg_word)
    );

    assign data_vld = pipe_mode ? preg_vld : s1_rd;
    assign q        = pipe_mode ? preg_word : rdata;
    assign q_drive  = data_vld && oe && !sleep;
endmodule

// File: rtl/lw_sram_chk.sv
module lw_sram_chk #(
    parameter int AW = 4,
    parameter int NB = 2,
    parameter int DW = 18
) (
    input logic          clk,
    input logic          rst_n,
    input logic          pipe_mode,
    input logic          sel_a,
    input logic          sel_b,
    input logic          sel_c,
    input logic          we,
    input logic          oe,
    input logic          sleep,
    input logic          q_drive,
    input logic [AW-1:0] addr,
    input logic [NB-1:0] be,
    input logic [DW-1:0] din,
    input logic [DW-1:0] q
);
    logic [1:0] since_rst;
    logic       rd_req;

    assign rd_req = sel_a && sel_b && sel_c && !we && !sleep;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               since_rst <= '0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    // R9: output enable low means no drive
    a_r9_oe_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        !oe |-> !q_drive);

    // R10: sleep forces the drive off
    a_r10_sleep_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |-> !q_drive);

    // R3: flow-through read drives one cycle after its request is seen
    a_r3_flow_drive: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst != 2'd0 && !pipe_mode && $past(rd_req) && oe && !sleep) |-> q_drive);

    // R1: no accepted read in flow-through mode means no drive
    a_r1_flow_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst != 2'd0 && !pipe_mode && !$past(rd_req)) |-> !q_drive);

    // R2: pipelined read drives two cycles after its request is seen
    a_r2_pipe_drive: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd3 && pipe_mode && $past(rd_req, 2) && oe && !sleep) |-> q_drive);
endmodule

bind lw_sram lw_sram_chk #(.AW(AW), .NB(NB), .DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pipe_mode (pipe_mode),
    .sel_a     (sel_a),
    .sel_b     (sel_b),
    .sel_c     (sel_c),
    .we        (we),
    .oe        (oe),
    .sleep     (sleep),
    .q_drive   (q_drive),
    .addr      (addr),
    .be        (be),
    .din       (din),
    .q         (q)
);

// File: tb/lw_sram_test.sv
module lw_sram_test;
    localparam int AW = 4;
    localparam int NB = 2;
    localparam int DW = 18;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pipe_mode = 1'b1;
    logic          sel_a = 1'b0, sel_b = 1'b0, sel_c = 1'b0;
    logic          we = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [NB-1:0] be = '0;
    logic [DW-1:0] din = '0;
    logic          oe = 1'b1;
    logic          sleep = 1'b0;
    logic [DW-1:0] q;
    logic          q_drive;

    int n_chk = 0;
    int n_err = 0;

    always #5 clk = ~clk;

    lw_sram #(.AW(AW), .NB(NB), .BW(9)) uut (
        .clk(clk), .rst_n(rst_n), .pipe_mode(pipe_mode),
        .sel_a(sel_a), .sel_b(sel_b), .sel_c(sel_c),
        .we(we), .addr(addr), .be(be), .din(din),
        .oe(oe), .sleep(sleep), .q(q), .q_drive(q_drive)
    );

    typedef struct packed {
        logic [2:0]    sel;
        logic          wr;
        logic [AW-1:0] a;
        logic [NB-1:0] bmask;
        logic [DW-1:0] data;
        logic [3:0]    req;
        logic          edrv;
        logic [DW-1:0] eq;
    } vec_t;

    // Pipelined mode, one row per edge; expectations are seen after that edge.
    localparam vec_t PVEC [16] = '{
        '{3'b111, 1'b1, 4'd1, 2'b11, 18'h00000, 4'd4,  1'b0, 18'h00000}, // R4 write A1
        '{3'b111, 1'b1, 4'd2, 2'b11, 18'h00000, 4'd6,  1'b0, 18'h00000}, // R6 write A2
        '{3'b111, 1'b0, 4'd1, 2'b00, 18'h1A5A5, 4'd4,  1'b0, 18'h00000}, // data for A1
        '{3'b111, 1'b0, 4'd2, 2'b00, 18'h0F0F0, 4'd2,  1'b1, 18'h1A5A5}, // R2 read A1 out
        '{3'b111, 1'b1, 4'd1, 2'b01, 18'h00000, 4'd6,  1'b1, 18'h0F0F0}, // R6 read A2 out
        '{3'b111, 1'b0, 4'd1, 2'b00, 18'h00000, 4'd2,  1'b0, 18'h00000}, // write slot, no drive
        '{3'b000, 1'b0, 4'd0, 2'b00, 18'h2AB55, 4'd7,  1'b1, 18'h1A555}, // R7 merged read
        '{3'b111, 1'b0, 4'd1, 2'b00, 18'h00000, 4'd1,  1'b0, 18'h00000}, // deselect before
        '{3'b000, 1'b0, 4'd0, 2'b00, 18'h00000, 4'd8,  1'b1, 18'h1A555}, // R8 retired write
        '{3'b101, 1'b1, 4'd2, 2'b11, 18'h00000, 4'd1,  1'b0, 18'h00000}, // R1 refused write
        '{3'b000, 1'b0, 4'd0, 2'b00, 18'h00000, 4'd1,  1'b0, 18'h00000},
        '{3'b000, 1'b0, 4'd0, 2'b00, 18'h3FFFF, 4'd1,  1'b0, 18'h00000},
        '{3'b111, 1'b0, 4'd2, 2'b00, 18'h00000, 4'd1,  1'b0, 18'h00000},
        '{3'b000, 1'b0, 4'd0, 2'b00, 18'h00000, 4'd1,  1'b1, 18'h0F0F0}, // R1 A2 unchanged
        '{3'b011, 1'b0, 4'd2, 2'b00, 18'h00000, 4'd1,  1'b0, 18'h00000}, // R1 partial select
        '{3'b000, 1'b0, 4'd0, 2'b00, 18'h00000, 4'd1,  1'b0, 18'h00000}  // R1 no drive
    };

    task automatic check(input string tag, input logic edrv, input logic [DW-1:0] eq,
                         input logic cmp_q);
        n_chk++;
        if (q_drive !== edrv || (cmp_q && q !== eq)) begin
            n_err++;
            $display("FAIL %s: q_drive=%0b q=%h expected q_drive=%0b q=%h",
                     tag, q_drive, q, edrv, eq);
        end
    endtask

    task automatic put(input logic [2:0] s, input logic w, input logic [AW-1:0] a,
                       input logic [NB-1:0] m, input logic [DW-1:0] d);
        {sel_a, sel_b, sel_c} = s;
        we = w; addr = a; be = m; din = d;
    endtask

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        #200000;
        n_chk++;
        n_err++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        // R11: reset state
        #12;
        check("R11 reset", 1'b0, '0, 1'b0);
        step();
        rst_n = 1'b1;
        step();

        // pipelined table
        for (int i = 0; i < 16; i++) begin
            put(PVEC[i].sel, PVEC[i].wr, PVEC[i].a, PVEC[i].bmask, PVEC[i].data);
            step();
            check($sformatf("R%0d row %0d", PVEC[i].req, i), PVEC[i].edrv, PVEC[i].eq,
                  PVEC[i].edrv);
        end

        // flow-through mode, entered under reset
        put(3'b000, 1'b0, '0, '0, '0);
        rst_n = 1'b0;
        pipe_mode = 1'b0;
        step();
        rst_n = 1'b1;
        step();

        // R3 R4 R6: write A5, data next edge alongside a read of A5
        put(3'b111, 1'b1, 4'd5, 2'b11, 18'h00000); step();
        check("R4 flow write slot", 1'b0, '0, 1'b0);
        put(3'b111, 1'b0, 4'd5, 2'b00, 18'h12345); step();
        check("R3 flow read after write", 1'b1, 18'h12345, 1'b1);

        // R5: upper byte only
        put(3'b111, 1'b1, 4'd5, 2'b10, 18'h00000); step();
        put(3'b000, 1'b0, 4'd0, 2'b00, 18'h3FFFF); step();
        check("R8 flow deselect during data", 1'b0, '0, 1'b0);
        put(3'b111, 1'b0, 4'd5, 2'b00, 18'h00000); step();
        check("R5 byte mask", 1'b1, 18'h3FF45, 1'b1);

        // R9: output enable acts mid-cycle
        oe = 1'b0; #1;
        check("R9 oe low", 1'b0, '0, 1'b0);
        oe = 1'b1; #1;
        check("R9 oe high again", 1'b1, 18'h3FF45, 1'b1);

        // R10: sleep acts mid-cycle, ignores a write, keeps contents
        put(3'b000, 1'b0, 4'd0, 2'b00, 18'h00000);
        sleep = 1'b1; #1;
        check("R10 sleep drive off", 1'b0, '0, 1'b0);
        put(3'b111, 1'b1, 4'd5, 2'b11, 18'h00000); step();
        put(3'b111, 1'b0, 4'd5, 2'b00, 18'h00001); step();
        check("R10 sleep read ignored", 1'b0, '0, 1'b0);
        sleep = 1'b0;
        put(3'b111, 1'b0, 4'd5, 2'b00, 18'h00000); step();
        check("R10 contents kept", 1'b1, 18'h3FF45, 1'b1);

        // R11: reset during a live read
        put(3'b000, 1'b0, 4'd0, 2'b00, 18'h00000);
        rst_n = 1'b0; #1;
        check("R11 reset mid read", 1'b0, '0, 1'b0);
        step();
        rst_n = 1'b1;
        step();
        check("R11 idle after reset", 1'b0, '0, 1'b0);

        finish_run();
    end
endmodule